// File: doc/BRIEF.md
# Hamming SEC/DED Codec

This block protects a data word with a single-error-correcting, double-error-detecting Hamming code. The encoder half is purely combinational: it places the data bits into a codeword whose positions are counted from 1, fills each power-of-two position with an even-parity check bit, and appends one parity bit over the whole word at codeword bit 0. The decoder half takes a codeword that may be corrupted. It recomputes the syndrome and the parity of the whole word, and from these two values it picks one of four outcomes. It then registers the outcome together with the corrected data, one clock after a valid input.

The data width is a parameter. The count of check bits is derived from it, so the same RTL builds an 8-bit variant with a 13-bit codeword and a 64-bit variant with a 72-bit codeword. The outcome register follows a small state set: CLEAN (0), FIXED (1), PAR_ONLY (2) and DOUBLE (3). Each valid input moves the register to the state that the classification picks. An idle cycle keeps the state and data but clears the output valid. Reset returns it to CLEAN.

Top module: `secded_codec`

## Requirements
- R1: The number of Hamming check bits p is the smallest value with 2^p >= p + DATA_W + 1. The codeword width is DATA_W + p + 1, which gives 13 bits for DATA_W=8 and 72 bits for DATA_W=64.
- R2: Codeword bit i (i >= 1) holds Hamming position i, and bit 0 holds the parity of the whole word. Data bits fill the positions that are not powers of two in ascending order, starting with the most significant data bit.
- R3: The check bit at position 2^k gives even parity over all positions whose index has bit k set. Bit 0 makes the parity of the whole codeword even. Data 8'h9A encodes to 13'h0A9C.
- R4: The encoder output is combinational and follows enc_data_i with no clock.
- R5: A codeword with no flipped bit decodes to status CLEAN (0) and the original data.
- R6: A single flipped bit at a position of 1 or more decodes to status FIXED (1) and the original data.
- R7: A flip of bit 0 alone decodes to status PAR_ONLY (2) and the original data.
- R8: Any two flipped bits decode to status DOUBLE (3). The data output is then the data field of the received codeword, uncorrected.
- R9: If the syndrome is nonzero, the word parity is odd and the syndrome is larger than the highest Hamming position, the result is status DOUBLE with uncorrected data. An example is flipping positions 1, 2 and 12 of the 8-bit variant.
- R10: dec_valid_o is high in the cycle after a cycle in which dec_valid_i is high, and dec_data_o and dec_status_o update with it.
- R11: After a cycle with dec_valid_i low, dec_valid_o is low and dec_data_o and dec_status_o keep their values.
- R12: During reset, dec_valid_o is 0, dec_status_o is CLEAN and dec_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | CODE_W | Encoded codeword (bit 0 = parity of the whole word) |
| dec_valid_i | input | 1 | Codeword on dec_code_i is valid this cycle |
| dec_code_i | input | CODE_W | Codeword to decode |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | DATA_W | Corrected data, or raw data on DOUBLE |
| dec_status_o | output | 2 | Outcome: 0 CLEAN, 1 FIXED, 2 PAR_ONLY, 3 DOUBLE |

## Verification
The clocked assertions assume that dec_valid_i and dec_code_i carry known values at every rising edge after reset. The syndrome range check assumes a known codeword whenever the classification reads FIXED. Any bit pattern on the codeword is legal, because even words with three or more errors must map to one of the four outcomes. The stimulus changes inputs only at falling edges and keeps dec_valid_i at a defined 0 or 1 from time zero. Corrupted words are built by flipping zero, one, two or three distinct, chosen bit positions of a correctly encoded word.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXED    = 2'd1,
        ST_PAR_ONLY = 2'd2,
        ST_DOUBLE   = 2'd3
    } dec_status_e;

    // Smallest p with 2^p >= p + dw + 1 (R1)
    function automatic int chk_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < (p + dw + 1)) p++;
        return p;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]                     data_i,
    output logic [DATA_W+chk_bits(DATA_W):0]      code_o
);
    localparam int P  = chk_bits(DATA_W);
    localparam int N  = DATA_W + P;
    localparam int CW = N + 1;

    logic [CW-1:0] word;
    logic          grp;
    int            di;

    always_comb begin
        word = '0;
        di   = DATA_W - 1;
        // R2: data MSB first into non-power-of-two positions
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                word[pos] = data_i[di];
                di        = di - 1;
            end
        end
        // R3: even parity per check group
        for (int k = 0; k < P; k++) begin
            grp = 1'b0;
            for (int pos = 1; pos <= N; pos++) begin
                if (pos[k]) grp = grp ^ word[pos];
            end
            word[1 << k] = grp;
        end
        word[0] = ^word[CW-1:1];
    end

    assign code_o = word;

endmodule

// File: rtl/secded_dec_core.sv
module secded_dec_core
    import secded_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W+chk_bits(DATA_W):0] code_i,
    output logic [chk_bits(DATA_W)-1:0]      syn_o,
    output dec_status_e                      status_o,
    output logic [DATA_W-1:0]                data_fix_o,
    output logic [DATA_W-1:0]                data_raw_o
);
    localparam int P  = chk_bits(DATA_W);
    localparam int N  = DATA_W + P;
    localparam int CW = N + 1;

    logic [P-1:0]  syn;
    logic          par_odd;
    logic          acc;
    logic [CW-1:0] fixed;
    dec_status_e   status;
    int            di;

    // Syndrome and overall parity
    always_comb begin
        for (int k = 0; k < P; k++) begin
            acc = 1'b0;
            for (int pos = 1; pos <= N; pos++) begin
                if (pos[k]) acc = acc ^ code_i[pos];
            end
            syn[k] = acc;
        end
        par_odd = ^code_i;
    end

    // Outcome classification (R5..R9)
    always_comb begin
        unique case ({(syn != '0), par_odd})
            2'b00: status = ST_CLEAN;
            2'b01: status = ST_PAR_ONLY;
            2'b11: status = (int'(syn) <= N) ? ST_FIXED : ST_DOUBLE;
            2'b10: status = ST_DOUBLE;
            default: status = ST_DOUBLE;
        endcase
    end

    // Correction and data extraction
    always_comb begin
        fixed = code_i;
        for (int pos = 1; pos <= N; pos++) begin
            if ((status == ST_FIXED) && (pos == int'(syn))) fixed[pos] = ~code_i[pos];
        end
        data_fix_o = '0;
        data_raw_o = '0;
        di = DATA_W - 1;
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_fix_o[di] = fixed[pos];
                data_raw_o[di] = code_i[pos];
                di = di - 1;
            end
        end
    end

    // R6: a correction always targets an existing Hamming position
    always_comb begin
        if (status == ST_FIXED) begin
            a_r6_fix_in_range: assert ((syn != '0) && (int'(syn) <= N));
        end
    end

    assign syn_o    = syn;
    assign status_o = status;

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [DATA_W-1:0]                     enc_data_i,
    output logic [DATA_W+chk_bits(DATA_W):0]      enc_code_o,
    input  logic                                  dec_valid_i,
    input  logic [DATA_W+chk_bits(DATA_W):0]      dec_code_i,
    output logic                                  dec_valid_o,
    output logic [DATA_W-1:0]                     dec_data_o,
    output logic [1:0]                            dec_status_o
);
    localparam int P = chk_bits(DATA_W);

    logic [P-1:0]      core_syn;
    dec_status_e       core_status;
    logic [DATA_W-1:0] core_fix;
    logic [DATA_W-1:0] core_raw;

    dec_status_e       state_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o)
    );

    secded_dec_core #(.DATA_W(DATA_W)) u_dec (
        .code_i     (dec_code_i),
        .syn_o      (core_syn),
        .status_o   (core_status),
        .data_fix_o (core_fix),
        .data_raw_o (core_raw)
    );

    // State register: outcome of the last accepted codeword
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= dec_valid_i;
            if (dec_valid_i) begin
                state_q <= core_status;
                data_q  <= core_fix;
            end
        end
    end

    // Outputs
    always_comb begin
        dec_valid_o  = valid_q;
        dec_data_o   = data_q;
        dec_status_o = state_q;
    end

    a_r10_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> (!dec_valid_o && $stable(dec_data_o) && $stable(dec_status_o)));

    a_r8_double_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && core_status == ST_DOUBLE) |=> (dec_data_o == $past(core_raw)));

    a_r7_paronly_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && core_status == ST_PAR_ONLY) |=> (dec_data_o == $past(core_raw)));

    a_r5_clean_syn: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && core_syn == '0 && core_status != ST_PAR_ONLY)
            |=> (dec_status_o == ST_CLEAN));

endmodule

// File: tb/sim_secded_codec.sv
`timescale 1ns/1ps
module sim_secded_codec;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]  e8;   logic [12:0] ec8;
    logic        v8 = 1'b0;  logic [12:0] c8 = '0;
    logic        vo8; logic [7:0] d8; logic [1:0] s8;
    logic [63:0] e64;  logic [71:0] ec64;
    logic        v64 = 1'b0; logic [71:0] c64 = '0;
    logic        vo64; logic [63:0] d64; logic [1:0] s64;

    secded_codec #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .enc_data_i(e8), .enc_code_o(ec8),
        .dec_valid_i(v8), .dec_code_i(c8), .dec_valid_o(vo8),
        .dec_data_o(d8), .dec_status_o(s8));

    secded_codec #(.DATA_W(64)) u1 (
        .clk(clk), .rst_n(rst_n), .enc_data_i(e64), .enc_code_o(ec64),
        .dec_valid_i(v64), .dec_code_i(c64), .dec_valid_o(vo64),
        .dec_data_o(d64), .dec_status_o(s64));

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_p(input int dw);
        int p = 1;
        while ((2 ** p) < (p + dw + 1)) p++;
        return p;
    endfunction

    function automatic logic [127:0] ref_enc(input logic [63:0] d, input int dw);
        logic [127:0] w = '0;
        int n = dw + ref_p(dw);
        int i = dw - 1;
        for (int pos = 1; pos <= n; pos++)
            if ((pos & (pos - 1)) != 0) begin w[pos] = d[i]; i--; end
        for (int pos = 1; pos <= n; pos++)
            if ((pos & (pos - 1)) != 0 && w[pos])
                for (int k = 0; (1 << k) <= n; k++)
                    if (pos[k]) w[1 << k] = ~w[1 << k];
        w[0] = ^w;
        return w;
    endfunction

    function automatic logic [63:0] ref_ext(input logic [127:0] w, input int dw);
        logic [63:0] d = '0;
        int n = dw + ref_p(dw);
        int i = dw - 1;
        for (int pos = 1; pos <= n; pos++)
            if ((pos & (pos - 1)) != 0) begin d[i] = w[pos]; i--; end
        return d;
    endfunction

    task automatic run_dec(input int wide, input logic [127:0] code,
                           input logic [63:0] exp_d, input logic [1:0] exp_s, input string req);
        @(negedge clk);
        if (wide != 0) begin v64 = 1'b1; c64 = code[71:0]; end
        else begin v8 = 1'b1; c8 = code[12:0]; end
        @(negedge clk);
        if (wide != 0) begin
            chk(vo64 == 1'b1, "R10 valid", {127'd0, vo64}, 128'd1);
            chk(s64 == exp_s, {req, " status"}, {126'd0, s64}, {126'd0, exp_s});
            chk(d64 == exp_d, {req, " data"}, {64'd0, d64}, {64'd0, exp_d});
            v64 = 1'b0;
        end else begin
            chk(vo8 == 1'b1, "R10 valid", {127'd0, vo8}, 128'd1);
            chk(s8 == exp_s, {req, " status"}, {126'd0, s8}, {126'd0, exp_s});
            chk(d8 == exp_d[7:0], {req, " data"}, {120'd0, d8}, {64'd0, exp_d});
            v8 = 1'b0;
        end
    endtask

    task automatic rand_case(input int wide, input int nflip);
        int dw = (wide != 0) ? 64 : 8;
        int cw = dw + ref_p(dw) + 1;
        logic [63:0] d = {$urandom, $urandom};
        logic [127:0] w, bad;
        int a, b;
        logic [1:0] es;
        logic [63:0] ed;
        if (dw == 8) d = {56'd0, d[7:0]};
        w = ref_enc(d, dw);
        bad = w;
        a = $urandom_range(cw - 1, 0);
        b = (a + 1 + $urandom_range(cw - 2, 0)) % cw;
        if (nflip >= 1) bad[a] = ~bad[a];
        if (nflip >= 2) bad[b] = ~bad[b];
        ed = d;
        if (nflip == 0) es = 2'd0;
        else if (nflip == 1) es = (a == 0) ? 2'd2 : 2'd1;
        else begin es = 2'd3; ed = ref_ext(bad, dw); end
        run_dec(wide, bad, ed,  es,
                (nflip == 0) ? "R5" : (nflip == 2) ? "R8" : (a == 0) ? "R7" : "R6");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [127:0] w;
        logic [12:0]  keep_d;
        logic [1:0]   keep_s;
        void'($urandom(32'd20240611));
        e8 = 8'h00; e64 = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(vo8 == 1'b0 && s8 == 2'd0 && d8 == 8'd0, "R12 reset", {115'd0, vo8, s8, d8}, 128'd0);
        chk(vo64 == 1'b0 && s64 == 2'd0 && d64 == 64'd0, "R12 reset64", {63'd0, vo64, d64}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 widths
        chk($bits(ec8) == 13, "R1 width8", 128'($bits(ec8)), 128'd13);
        chk($bits(ec64) == 72, "R1 width64", 128'($bits(ec64)), 128'd72);

        // R3 directed example, R4 combinational
        e8 = 8'h9A; #1;
        chk(ec8 == 13'h0A9C, "R3 example", {115'd0, ec8}, 128'h0A9C);
        for (int i = 0; i < 40; i++) begin
            e8 = 8'($urandom); e64 = {$urandom, $urandom}; #1;
            w = ref_enc({56'd0, e8}, 8);
            chk(ec8 == w[12:0], "R2 R4 enc8", {115'd0, ec8}, w);
            w = ref_enc(e64, 64);
            chk(ec64 == w[71:0], "R2 R3 enc64", {56'd0, ec64}, w);
        end

        // Directed decoder corners
        w = ref_enc(64'h9A, 8);
        run_dec(0, w, 64'h9A, 2'd0, "R5 clean");
        w[10] = ~w[10];
        run_dec(0, w, 64'h9A, 2'd1, "R6 pos10");
        w = ref_enc(64'h9A, 8); w[0] = ~w[0];
        run_dec(0, w, 64'h9A, 2'd2, "R7 par bit");
        w = ref_enc(64'h9A, 8); w[1] = ~w[1]; w[2] = ~w[2]; w[12] = ~w[12];
        run_dec(0, w, ref_ext(w, 8), 2'd3, "R9 syn15");
        w = ref_enc(64'h9A, 8); w[3] = ~w[3]; w[0] = ~w[0];
        run_dec(0, w, ref_ext(w, 8), 2'd3, "R8 with par");

        // R11 idle hold
        keep_d = {5'd0, d8}; keep_s = s8;
        @(negedge clk);
        chk(vo8 == 1'b0, "R11 valid low", {127'd0, vo8}, 128'd0);
        chk(d8 == keep_d[7:0] && s8 == keep_s, "R11 hold", {118'd0, s8, d8}, {118'd0, keep_s, keep_d[7:0]});

        // Random mixes
        for (int i = 0; i < 300; i++) rand_case(0, i % 3);
        for (int i = 0; i < 300; i++) rand_case(1, i % 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule